// File: doc/BRIEF.md
# Four-Lane Single-Precision Min/Max Unit

This block takes two 128-bit operands, each carrying four IEEE-754 single-precision lanes. For every lane it returns either the larger or the smaller of the pair. It never does arithmetic: a result lane is always a bit-exact copy of one of the two inputs. It raises no exception flags.

A second mode works on the lowest lane only. In that mode lane 0 is reduced as usual and the three upper lanes are copied from operand A. A fixed, asymmetric rule settles NaNs, zeros of opposite sign and equal values: in each of those cases the lane takes operand B's bits. This lets software build commutative min/max out of ordered operand placement.

By default the result is registered. `out_valid` follows `in_valid` by one clock, and `result` holds its value until the next accepted input. A parameter selects a purely combinational variant instead.

Top module: `fmm_unit`

## Requirements
- R1: Lane k occupies bits 32k+31:32k of `a`, `b` and `result` (lane 0 at 31:0, lane 3 at 127:96). In packed mode (`scalar`=0) each lane is reduced independently of the others, and every result lane is a bit-exact copy of A's lane or B's lane.
- R2: With `op_max`=1, a lane gets A's value when A is strictly greater than B, and B's value otherwise.
- R3: With `op_max`=0, a lane gets A's value when A is strictly smaller than B, and B's value otherwise.
- R4: With `scalar`=1, only lane 0 is reduced, and result lanes 1 to 3 equal operand A's lanes 1 to 3 unchanged.
- R5: If either lane input is a NaN (exponent field all ones and fraction nonzero, any sign), the result lane is B's lane unchanged.
- R6: If both lane inputs are zeros (magnitude bits 30:0 all zero), whatever their signs, the result lane is B's lane. Equal values likewise give B.
- R7: Ordering is sign-magnitude. Any negative non-zero value is below any positive value. Between two negatives, the larger magnitude is the smaller value. Infinities order as the largest magnitudes.
- R8: Denormal inputs are compared exactly as encoded, with no flush to zero. The smallest positive denormal is greater than +0 and greater than any negative value.
- R9: With the registered option, `out_valid` is 1 exactly one clock after an edge with `in_valid`=1 and 0 otherwise. After reset, `out_valid` and `result` are 0.
- R10: While `in_valid` is 0, `result` keeps the value of the last accepted input, whatever `a`, `b`, `op_max` and `scalar` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input strobe; operands are accepted on a clock edge while it is 1 |
| op_max | input | 1 | 1 = maximum, 0 = minimum |
| scalar | input | 1 | 1 = lane 0 only, upper lanes from A; 0 = all lanes |
| a | input | 128 | First operand, four 32-bit lanes |
| b | input | 128 | Second operand, four 32-bit lanes |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Four 32-bit result lanes |

## Verification
The bench sweeps all ordered pairs from a set of sixteen encodings through every op and mode combination. The set covers both zeros, both infinities, quiet, signalling and negative NaNs, the extreme denormals and the largest finite values of each sign. Lanes are fed rotated pairs, so a crossed lane shows up as a wrong lane value.

Each kind of fault shows up as a distinct error:
- A design that treated -0 and +0 as ordered would return A on the opposite-sign zero pairs.
- One that compared raw bits as unsigned or as two's complement would misorder negatives.
- One that flushed denormals would return B for a denormal against zero.
- One that favoured the non-NaN operand would return A where B is expected.

Separate checks cover the pass-through of A's upper lanes in scalar mode and the hold of the result while the strobe is low.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned FP_W   = EXP_W + FRAC_W + 1;
  localparam int unsigned MAG_W  = FP_W - 1;

  typedef logic [FP_W-1:0] fp_t;

  typedef enum logic {
    OP_MIN = 1'b0,
    OP_MAX = 1'b1
  } fmm_op_e;

  // exponent all ones with a nonzero fraction
  function automatic logic fp_is_nan(input fp_t x);
    return (&x[MAG_W-1:FRAC_W]) && (|x[FRAC_W-1:0]);
  endfunction

  // zero of either sign
  function automatic logic fp_is_zero(input fp_t x);
    return ~|x[MAG_W-1:0];
  endfunction

  // strict sign-magnitude "x below y"; both-zero is never ordered
  function automatic logic fp_below(input fp_t x, input fp_t y);
    logic sx, sy;
    sx = x[FP_W-1];
    sy = y[FP_W-1];
    if (fp_is_zero(x) && fp_is_zero(y)) return 1'b0;
    if (sx != sy)                       return sx;
    if (!sx)                            return x[MAG_W-1:0] < y[MAG_W-1:0];
    return x[MAG_W-1:0] > y[MAG_W-1:0];
  endfunction

endpackage

// File: rtl/fmm_lane.sv
module fmm_lane
  import fmm_pkg::*;
(
  input  fp_t     a_i,
  input  fp_t     b_i,
  input  fmm_op_e op_i,
  output fp_t     y_o,
  output logic    nan_hit_o,
  output logic    zero_tie_o,
  output logic    a_wins_o
);

  logic a_lt_b;
  logic b_lt_a;

  always_comb begin
    nan_hit_o  = fp_is_nan(a_i) || fp_is_nan(b_i);
    zero_tie_o = fp_is_zero(a_i) && fp_is_zero(b_i);
    a_lt_b     = fp_below(a_i, b_i);
    b_lt_a     = fp_below(b_i, a_i);
    // A is chosen only when strictly favoured; every other case falls to B
    if (nan_hit_o)          a_wins_o = 1'b0;
    else if (op_i == OP_MAX) a_wins_o = b_lt_a;
    else                     a_wins_o = a_lt_b;
    y_o = a_wins_o ? a_i : b_i;
  end

endmodule

// File: rtl/fmm_array.sv
module fmm_array
  import fmm_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned VEC_W = LANES * FP_W
)(
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  fmm_op_e          op_i,
  input  logic             scalar_i,
  output logic [VEC_W-1:0] y_o,
  output logic [LANES-1:0] nan_vec_o,
  output logic [LANES-1:0] tie_vec_o,
  output logic [LANES-1:0] a_win_vec_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp_t lane_y;

    fmm_lane u_lane (
      .a_i        (a_i[g*FP_W +: FP_W]),
      .b_i        (b_i[g*FP_W +: FP_W]),
      .op_i       (op_i),
      .y_o        (lane_y),
      .nan_hit_o  (nan_vec_o[g]),
      .zero_tie_o (tie_vec_o[g]),
      .a_wins_o   (a_win_vec_o[g])
    );

    if (g == 0) begin : g_low
      assign y_o[g*FP_W +: FP_W] = lane_y;
    end else begin : g_high
      // scalar mode passes the first operand through on upper lanes
      assign y_o[g*FP_W +: FP_W] = scalar_i ? a_i[g*FP_W +: FP_W] : lane_y;
    end
  end

endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned VEC_W     = LANES * FP_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_max,
  input  logic             scalar,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);

  fmm_op_e          op_sel;
  logic [VEC_W-1:0] comb_y;
  logic [LANES-1:0] nan_vec;
  logic [LANES-1:0] tie_vec;
  logic [LANES-1:0] a_win_vec;

  assign op_sel = op_max ? OP_MAX : OP_MIN;

  fmm_array #(.LANES(LANES)) u_array (
    .a_i         (a),
    .b_i         (b),
    .op_i        (op_sel),
    .scalar_i    (scalar),
    .y_o         (comb_y),
    .nan_vec_o   (nan_vec),
    .tie_vec_o   (tie_vec),
    .a_win_vec_o (a_win_vec)
  );

  // lane 0 result always equals one of its inputs (R1)
  p_pick_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (comb_y[FP_W-1:0] == a[FP_W-1:0]) || (comb_y[FP_W-1:0] == b[FP_W-1:0]));

  // a NaN never lets A win (R5)
  p_nan_no_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nan_vec[0] |-> !a_win_vec[0]);

  if (REGISTERED) begin : g_reg
    logic             vld_q;
    logic [VEC_W-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) res_q <= comb_y;
      end
    end

    assign out_valid = vld_q;
    assign result    = res_q;

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
    p_scalar_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && scalar |=> result[VEC_W-1:FP_W] == $past(a[VEC_W-1:FP_W]));
    p_nan_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && nan_vec[0] |=> result[FP_W-1:0] == $past(b[FP_W-1:0]));
    p_tie_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && tie_vec[0] |=> result[FP_W-1:0] == $past(b[FP_W-1:0]));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = comb_y;
  end

endmodule

// File: tb/test_fmm_unit.sv
module test_fmm_unit;

  localparam int LANES = 4;
  localparam int W     = 32;
  localparam int VW    = LANES * W;
  localparam int NV    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          op_max = 1'b0;
  logic          scalar = 1'b0;
  logic [VW-1:0] a = '0;
  logic [VW-1:0] b = '0;
  logic          out_valid;
  logic [VW-1:0] result;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fmm_unit #(.LANES(LANES), .REGISTERED(1'b1)) i_fmm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_max(op_max),
    .scalar(scalar), .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  logic [31:0] vals [NV];
  initial begin
    vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
    vals[2]  = 32'h3F80_0000; vals[3]  = 32'hBF80_0000;
    vals[4]  = 32'h4000_0000; vals[5]  = 32'hC000_0000;
    vals[6]  = 32'h0000_0001; vals[7]  = 32'h8000_0001;
    vals[8]  = 32'h007F_FFFF; vals[9]  = 32'h7F7F_FFFF;
    vals[10] = 32'hFF7F_FFFF; vals[11] = 32'h7F80_0000;
    vals[12] = 32'hFF80_0000; vals[13] = 32'h7FC0_0000;
    vals[14] = 32'h7F80_0001; vals[15] = 32'hFFC0_0001;
  end

  function automatic bit m_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // monotonic unsigned key for the real-number order
  function automatic logic [31:0] m_key(input logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic logic [31:0] m_pick(input logic [31:0] x, input logic [31:0] y,
                                         input bit mx);
    if (m_nan(x) || m_nan(y)) return y;                       // R5
    if (x[30:0] == 0 && y[30:0] == 0) return y;               // R6
    if (mx) return (m_key(x) > m_key(y)) ? x : y;             // R2
    return (m_key(x) < m_key(y)) ? x : y;                     // R3
  endfunction

  function automatic string m_tag(input logic [31:0] x, input logic [31:0] y,
                                  input bit mx, input bit sc);
    if (m_nan(x) || m_nan(y)) return "R5";
    if (x[30:0] == 0 && y[30:0] == 0) return "R6";
    if (sc) return "R4";
    if (x[31] && y[31]) return "R7";
    if ((x[30:23] == 0 && x[22:0] != 0) || (y[30:23] == 0 && y[22:0] != 0)) return "R8";
    if (x == y) return "R6";
    return mx ? "R2" : "R3";
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [VW-1:0] last_exp;

  // drive at a negative edge, check at the next negative edge
  task automatic run_vec(input int ia, input int ib, input bit mx, input bit sc);
    logic [VW-1:0] ea;
    logic [VW-1:0] eb;
    logic [VW-1:0] er;
    string tg;
    for (int l = 0; l < LANES; l++) begin
      ea[l*W +: W] = vals[(ia + l*5) % NV];
      eb[l*W +: W] = vals[(ib + l*3) % NV];
      er[l*W +: W] = (sc && l > 0) ? ea[l*W +: W]
                                   : m_pick(ea[l*W +: W], eb[l*W +: W], mx);
    end
    tg = m_tag(ea[W-1:0], eb[W-1:0], mx, sc);
    if (!sc && ia == ib + 1) tg = "R1";
    a = ea; b = eb; op_max = mx; scalar = sc; in_valid = 1'b1;
    @(negedge clk);
    check("R9 valid", {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, 1'b1});
    check(tg, result, er);
    last_exp = er;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", {{(VW-1){1'b0}}, out_valid}, '0);
    check("R9 reset result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep R1 R2 R3 R4 R5 R6 R7 R8
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int ia = 0; ia < NV; ia++)
          for (int ib = 0; ib < NV; ib++)
            run_vec(ia, ib, m[0], s[0]);

    // R10 hold with inputs changing while the strobe is low
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      a = ~a; b = {b[VW-2:0], b[VW-1]}; op_max = ~op_max; scalar = ~scalar;
      @(negedge clk);
      check("R10 hold", result, last_exp);
      check("R9 idle valid", {{(VW-1){1'b0}}, out_valid}, '0);
    end

    // R8 explicit: min denormal vs +0 under max gives the denormal
    run_vec(6, 0, 1'b1, 1'b0);
    check("R8 denorm", {96'b0, result[31:0]}, {96'b0, 32'h0000_0001});
    in_valid = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule